// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Collector

This block gathers thirty-two asynchronous interrupt lines into one pending register. Each line is brought into the clock domain, reduced to a per-source event according to its configured sense, and latched. Software reads and acknowledges the latched events over a small word-addressed register port. It can mask each source and steer each one to either of two interrupt outputs: a normal one and an urgent one. Either output can drive a parent controller, so several of these blocks can be chained in a tree.

A source is either edge or level sensitive, and its polarity is set separately. Pending bits are cleared by writing ones. A level source that is still asserted cannot be acknowledged. Each source has a register bit position that is the mirror of its source number. Vector generation is not provided, and those offsets read as zero.

Top module: `irqc_top`

## Requirements
- R1: While reset is held, every register reads zero and both interrupt outputs are low. After release, every source is disabled, level sensitive, active low and routed to the normal output.
- R2: Source n occupies register bit 31-n. The word offsets are: pending 0x0, enable 0x2, urgent select 0x3, polarity 0x4, sense 0x5, masked pending 0x6.
- R3: Writing offset 0x0 clears every pending bit whose write-data bit is 1 and leaves bits written 0 unchanged.
- R4: A sense bit of 1 selects edge detection and 0 selects level detection. A polarity bit of 1 selects a rising edge or a high level, and 0 selects a falling edge or a low level. An edge that returns to the inactive level sets nothing.
- R5: For a level source, a clear has no effect while the synchronised input is at its active level, whether or not the source is enabled. Once the input is inactive, the bit stays set until it is cleared.
- R6: Pending bits latch whether or not the source is enabled. Masked pending reads as pending AND enable.
- R7: The urgent output is a register of the OR of masked pending bits whose urgent-select bit is 1. The normal output is the same over bits whose urgent-select bit is 0. Both are low when no enabled source is pending.
- R8: When a clear write and a new event for the same source fall in the same cycle, the bit ends up set.
- R9: Offsets 0x1, 0x7, 0x8 and 0x9 to 0xF read zero. Writes to them, and to offset 0x6, change no register.
- R10: Each input passes through a two-flop synchroniser. A change on an input shows in the pending register after the third rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Raw interrupt lines, bit n is source n |
| reg_addr_i | input | 4 | Register word offset |
| reg_we_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| irq_noncrit_o | output | 1 | Normal interrupt request |
| irq_crit_o | output | 1 | Urgent interrupt request |

## Verification
The assertions assume that the write strobe is sampled with a stable address and data at the rising edge. They also assume that the raw lines change only between edges, so the synchroniser never sees a change at the edge itself. The bench drives every input, including the raw lines, on the falling edge and holds the write strobe for exactly one rising edge. For the same-cycle clear test, it aligns the write with the cycle in which the synchronised edge first reaches the detector.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int unsigned SRC_COUNT = 32;
    localparam int unsigned ADDR_BITS = 4;
    // register word offsets
    localparam int unsigned OFS_PEND  = 0;
    localparam int unsigned OFS_ENA   = 2;
    localparam int unsigned OFS_URG   = 3;
    localparam int unsigned OFS_POL   = 4;
    localparam int unsigned OFS_SENSE = 5;
    localparam int unsigned OFS_MASK  = 6;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] sense_i,
    output logic [W-1:0] event_o
);
    logic [W-1:0] prev_d, prev_q;
    logic [W-1:0] active, edge_hit;

    always_comb begin
        prev_d   = line_i;
        active   = ~(line_i ^ pol_i);
        edge_hit = (line_i ^ prev_q) & active;
        event_o  = (sense_i & edge_hit) | (~sense_i & active);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    // R4: an edge-sensed source never fires while its line holds still
    a_r4_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        ((event_o & sense_i & ~(line_i ^ prev_q)) == '0));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NSRC = SRC_COUNT,
    parameter int AW   = ADDR_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [AW-1:0]   reg_addr_i,
    input  logic            reg_we_i,
    input  logic [NSRC-1:0] reg_wdata_i,
    output logic [NSRC-1:0] reg_rdata_o,
    output logic            irq_noncrit_o,
    output logic            irq_crit_o
);
    localparam int TOP = NSRC - 1;

    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic [NSRC-1:0] ena;
        logic [NSRC-1:0] urg;
        logic [NSRC-1:0] pol;
        logic [NSRC-1:0] sense;
        logic            out_nc;
        logic            out_cr;
    } state_t;

    state_t st_d, st_q;
    logic [NSRC-1:0] raw_mapped, line_s, ev, clr, masked;
    logic sel_pend, sel_ena, sel_urg, sel_pol, sel_sense, sel_mask;

    // source n lives at bit TOP-n
    for (genvar n = 0; n < NSRC; n++) begin : g_map
        assign raw_mapped[TOP-n] = src_i[n];
    end

    irqc_sync #(.W(NSRC), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw_mapped), .sync_o(line_s)
    );

    irqc_detect #(.W(NSRC)) u_det (
        .clk(clk), .rst_n(rst_n), .line_i(line_s),
        .pol_i(st_q.pol), .sense_i(st_q.sense), .event_o(ev)
    );

    always_comb begin
        sel_pend  = reg_addr_i == AW'(OFS_PEND);
        sel_ena   = reg_addr_i == AW'(OFS_ENA);
        sel_urg   = reg_addr_i == AW'(OFS_URG);
        sel_pol   = reg_addr_i == AW'(OFS_POL);
        sel_sense = reg_addr_i == AW'(OFS_SENSE);
        sel_mask  = reg_addr_i == AW'(OFS_MASK);
    end

    always_comb begin
        st_d   = st_q;
        masked = st_q.pend & st_q.ena;
        clr    = (reg_we_i && sel_pend) ? reg_wdata_i : '0;
        st_d.pend = (st_q.pend & ~clr) | ev;
        if (reg_we_i) begin
            if (sel_ena)   st_d.ena   = reg_wdata_i;
            if (sel_urg)   st_d.urg   = reg_wdata_i;
            if (sel_pol)   st_d.pol   = reg_wdata_i;
            if (sel_sense) st_d.sense = reg_wdata_i;
        end
        st_d.out_cr = |(masked & st_q.urg);
        st_d.out_nc = |(masked & ~st_q.urg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata_o = '0;
        if (sel_pend)  reg_rdata_o = st_q.pend;
        if (sel_ena)   reg_rdata_o = st_q.ena;
        if (sel_urg)   reg_rdata_o = st_q.urg;
        if (sel_pol)   reg_rdata_o = st_q.pol;
        if (sel_sense) reg_rdata_o = st_q.sense;
        if (sel_mask)  reg_rdata_o = st_q.pend & st_q.ena;
    end

    assign irq_crit_o    = st_q.out_cr;
    assign irq_noncrit_o = st_q.out_nc;

    // R7: urgent request follows an enabled, urgent-routed pending bit
    a_r7_urgent_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (|(st_q.pend & st_q.ena & st_q.urg)) |=> irq_crit_o);
    a_r7_normal_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (|(st_q.pend & st_q.ena & ~st_q.urg)) |=> irq_noncrit_o);
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.pend & st_q.ena) == '0) |=> (!irq_crit_o && !irq_noncrit_o));
    // R8 and R5: any detected event is pending on the next cycle, clear or not
    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.pend & $past(ev)) == $past(ev)));
    // R3: written ones without a competing event are gone next cycle
    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && sel_pend) |=> ((st_q.pend & $past(reg_wdata_i & ~ev)) == '0));
    // R9: unmapped offsets read zero
    a_r9_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_pend || sel_ena || sel_urg || sel_pol || sel_sense || sel_mask)
        |-> (reg_rdata_o == '0));
endmodule

// File: tb/sim_irqc_top.sv
`timescale 1ns/1ps
module sim_irqc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] srcv = '0;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_nc, irq_cr;
    int          nchk = 0;
    int          nerr = 0;
    logic [31:0] v, b;

    always #4 clk = ~clk;

    irqc_top u0 (
        .clk(clk), .rst_n(rst_n), .src_i(srcv), .reg_addr_i(addr),
        .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .irq_noncrit_o(irq_nc), .irq_crit_o(irq_cr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic settle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        #1_000_000;
        nchk++; nerr++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R1: reset values
        settle(3);
        for (int a = 0; a < 16; a++) begin
            addr = 4'(a); #1;
            chk("R1 reg under reset", rdata, 32'h0);
        end
        chk("R1 outputs under reset", {30'b0, irq_cr, irq_nc}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        settle(5);
        // R1/R4: default is level active-low, lines are low -> all pending
        rd(0, v); chk("R1 R4 default level-low latch", v, 32'hFFFF_FFFF);
        rd(6, v); chk("R1 R6 disabled after reset", v, 32'h0);
        chk("R1 R7 outputs idle", {30'b0, irq_cr, irq_nc}, 32'h0);

        // R3: partial clear with edge-sensed rising sources
        wr(4, '1); wr(5, '1); settle(2); wr(0, '1); settle(2);
        rd(0, v); chk("R3 all cleared", v, 32'h0);
        srcv = '1; settle(5);
        rd(0, v); chk("R4 every rising edge latched", v, 32'hFFFF_FFFF);
        wr(0, 32'h0000_FFFF); settle(1);
        rd(0, v); chk("R3 zeros leave bits", v, 32'hFFFF_0000);
        wr(0, '1); settle(1);
        rd(0, v); chk("R3 clear all", v, 32'h0);
        srcv = '0; settle(5);
        rd(0, v); chk("R4 return edge sets nothing", v, 32'h0);

        // R2 R4 R5 R6 R7: sweep every source in every sense/polarity mode
        for (int n = 0; n < 32; n++) begin
            for (int m = 0; m < 4; m++) begin
                logic t, p;
                t = m[1]; p = m[0];
                b = 32'h8000_0000 >> n;
                wr(4, p ? '1 : '0); wr(5, t ? '1 : '0);
                wr(2, '0); wr(3, '0);
                srcv = p ? '0 : '1;
                settle(5); wr(0, '1); settle(2);
                rd(0, v); chk("R3 idle clear", v, 32'h0);
                wr(2, b); wr(3, n[0] ? b : 32'h0);
                srcv[n] = p; settle(5);
                rd(0, v); chk("R2 R4 mapped pending bit", v, b);
                rd(6, v); chk("R6 masked pending", v, b);
                chk("R7 urgent output", {31'b0, irq_cr}, {31'b0, n[0]});
                chk("R7 normal output", {31'b0, irq_nc}, {31'b0, ~n[0]});
                wr(0, b); settle(1);
                rd(0, v); chk("R5 R3 clear while active", v, t ? 32'h0 : b);
                srcv[n] = ~p; settle(5);
                rd(0, v); chk("R5 R4 after line returns", v, t ? 32'h0 : b);
                wr(0, b); settle(3);
                rd(0, v); chk("R3 final clear", v, 32'h0);
                chk("R7 outputs drop", {30'b0, irq_cr, irq_nc}, 32'h0);
            end
        end

        // R5: level hold while disabled
        wr(4, '1); wr(5, '0); wr(2, '0); srcv = '0; settle(5); wr(0, '1);
        srcv[9] = 1'b1; settle(5);
        wr(0, 32'h0040_0000); settle(2);
        rd(0, v); chk("R5 disabled level holds", v, 32'h0040_0000);
        rd(6, v); chk("R6 disabled not masked in", v, 32'h0);
        srcv[9] = 1'b0; settle(5); wr(0, '1); settle(1);
        rd(0, v); chk("R5 clears once inactive", v, 32'h0);

        // R8 R10 R6: event and clear in the same cycle, source disabled
        wr(5, '1); settle(3); wr(0, '1); settle(1);
        @(negedge clk); srcv[5] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); addr = 4'h0; #1;
        chk("R10 not yet after two edges", rdata, 32'h0);
        wdata = 32'h0400_0000; we = 1'b1;
        @(negedge clk); we = 1'b0; #1;
        chk("R8 R10 event wins over clear", rdata, 32'h0400_0000);
        rd(6, v); chk("R6 latched though disabled", v, 32'h0);
        chk("R7 no output when disabled", {30'b0, irq_cr, irq_nc}, 32'h0);

        // R9: holes read zero, writes to holes and masked view ignored
        wr(2, 32'h0F0F_0000); wr(3, 32'h00F0_0000);
        wr(1, '1); wr(6, '1); wr(7, '1); wr(8, '1); wr(15, '1);
        for (int a = 7; a < 16; a++) begin
            rd(4'(a), v); chk("R9 hole reads zero", v, 32'h0);
        end
        rd(1, v); chk("R9 offset 1 zero", v, 32'h0);
        rd(2, v); chk("R9 enable untouched", v, 32'h0F0F_0000);
        rd(3, v); chk("R9 urgent untouched", v, 32'h00F0_0000);
        rd(4, v); chk("R9 polarity untouched", v, 32'hFFFF_FFFF);
        rd(5, v); chk("R9 sense untouched", v, 32'hFFFF_FFFF);
        rd(0, v); chk("R9 pending untouched", v, 32'h0400_0000);
        rd(6, v); chk("R6 R9 masked view", v, 32'h0400_0000);
        settle(2);
        chk("R7 normal set", {30'b0, irq_cr, irq_nc}, 32'h1);

        finish_run();
    end
endmodule